// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a watchdog timer attached to a simple single-cycle register bus. Software loads a 16-bit reload value and a few mode bits into a control word. A down-counter then runs from that value, once per system clock or once every 2048 clocks when the prescaler is on. If the counter is allowed to run out, the block raises a one-cycle request on one of two outputs. One output asks for a system reset and the other asks for a non-maskable interrupt; a control bit chooses which.

To keep the counter from running out, software writes two fixed 16-bit keys to the service register in order. Any other value breaks the sequence, so a runaway program that writes random values cannot keep the timer alive by accident. A debug freeze input can halt counting when the control word allows it. The current count can be read back at any time.

Top module: `kwdog_top`

## Requirements
- R1: Writing 0x556C and then 0xAA39 to the low 16 bits of offset 0xC reloads the counter from the reload value and restarts the prescaler. The count reads back the reload value in the cycle after the second write.
- R2: The service keys must come in order. A 0x556C write arms the sequence, and a repeated 0x556C keeps it armed. Any other value written while armed disarms it. A 0xAA39 write that is not armed has no effect on the count.
- R3: The control word is at offset 0x4. Bits 31:16 hold the reload value, bit 3 is freeze enable, bit 2 is the watchdog enable, bit 1 is the reset select and bit 0 is the prescaler enable. A read returns these bits with every other bit zero. Every write to the control word reloads the counter from the newly written reload value.
- R4: The count register is at offset 0x8. It returns the counter in bits 15:0 with zeros above, and writes to it are ignored. Reads of offset 0x0, reads of any address whose two low bits are not zero, and reads of the service register all return zero.
- R5: With the prescaler off and the watchdog enabled, the counter drops by one every clock. A tick that finds the counter at zero is an expiry, so the expiry comes reload+1 clocks after a load.
- R6: With the prescaler on, the counter drops once every 2048 clocks. The first decrement comes 2048 clocks after a load, and the expiry comes (reload+1)×2048 clocks after a load.
- R7: With reset select at 0, an expiry gives a one-cycle pulse on `nmi_req_o`. The counter then reloads and keeps running, so the next pulse follows reload+1 ticks later. `rst_req_o` and `nmi_req_o` are never high together.
- R8: With reset select at 1, an expiry gives a single one-cycle pulse on `rst_req_o`. The counter then stays at zero, and neither service keys nor control writes restart it until `rst_n` is asserted.
- R9: While the enable bit is clear, the counter is held at the reload value, the prescaler is held at zero and no expiry pulse is produced.
- R10: When freeze enable is set and `dbg_freeze_i` is high, the counter and the prescaler hold their values. When freeze enable is clear, `dbg_freeze_i` has no effect.
- R11: After reset the control word reads 0, the count reads 0, and both request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel_i | input | 1 | Bus access in this cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 4 | Byte offset within the 16-byte block |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid in the same cycle as the read |
| dbg_freeze_i | input | 1 | Debug halt request |
| rst_req_o | output | 1 | One-cycle system reset request |
| nmi_req_o | output | 1 | One-cycle non-maskable interrupt request |

## Verification
A write takes effect at the clock edge that ends its bus cycle. A read returns, in the same cycle, the state as it stood after the previous edge. So a count read in the cycle after the edge k clocks past a load shows reload−k, and a read issued right after a service sequence shows the reload value. The expiry request is registered. It is high in the cycle after the edge numbered reload+1 (times 2048 when the prescaler is on), counted from the load edge. The bench issues one bus operation per cycle so that these edge counts are exact. It compares reads in a scoreboard at the falling edge inside the read cycle, and it times expiries by counting falling edges from the load until the first request appears.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

  // Control-word bit positions that software decodes.
  localparam int unsigned CTL_PRE_BIT = 0;
  localparam int unsigned CTL_RSEL_BIT = 1;
  localparam int unsigned CTL_EN_BIT = 2;
  localparam int unsigned CTL_FRZ_BIT = 3;
  localparam int unsigned CTL_FLAG_W = 4;

  // Word indices within the register block (byte offset / 4).
  localparam int unsigned IDX_CTRL = 1;
  localparam int unsigned IDX_COUNT = 2;
  localparam int unsigned IDX_SVC = 3;

  typedef struct packed {
    logic frz_en;
    logic wd_en;
    logic rst_sel;
    logic pre_en;
  } ctrl_flags_t;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_t;

  function automatic ctrl_flags_t flags_from_nibble(input logic [CTL_FLAG_W-1:0] n);
    ctrl_flags_t f;
    f.frz_en = n[CTL_FRZ_BIT];
    f.wd_en = n[CTL_EN_BIT];
    f.rst_sel = n[CTL_RSEL_BIT];
    f.pre_en = n[CTL_PRE_BIT];
    return f;
  endfunction

  function automatic logic [CTL_FLAG_W-1:0] nibble_from_flags(input ctrl_flags_t f);
    logic [CTL_FLAG_W-1:0] n;
    n = '0;
    n[CTL_FRZ_BIT] = f.frz_en;
    n[CTL_EN_BIT] = f.wd_en;
    n[CTL_RSEL_BIT] = f.rst_sel;
    n[CTL_PRE_BIT] = f.pre_en;
    return n;
  endfunction

endpackage

// File: rtl/kwdog_regs.sv
module kwdog_regs
  import kwdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SVC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic [CNT_W-1:0]  cnt_i,
  output logic              ctrl_wr_o,
  output logic              svc_wr_o,
  output logic [SVC_W-1:0]  svc_data_o,
  output logic [CNT_W-1:0]  tc_o,
  output logic [CNT_W-1:0]  reload_val_o,
  output ctrl_flags_t       flags_o
);

  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam int unsigned RSV_W = DATA_W - CNT_W - CTL_FLAG_W;
  localparam int unsigned CNT_PAD_W = DATA_W - CNT_W;

  logic              aligned;
  logic [WORD_W-1:0] word_idx;
  logic              hit_ctrl;
  logic              hit_svc;
  logic              rd_en;
  logic [CNT_W-1:0]  tc_q;
  ctrl_flags_t       flags_q;

  // Only word-aligned accesses reach a register.
  assign aligned = (bus_addr_i[1:0] == 2'b00);
  assign word_idx = bus_addr_i[ADDR_W-1:2];
  assign hit_ctrl = bus_sel_i && aligned && (word_idx == WORD_W'(IDX_CTRL));
  assign hit_svc = bus_sel_i && aligned && (word_idx == WORD_W'(IDX_SVC));
  assign rd_en = bus_sel_i && !bus_wr_i && aligned;

  assign ctrl_wr_o = hit_ctrl && bus_wr_i;
  assign svc_wr_o = hit_svc && bus_wr_i;
  assign svc_data_o = bus_wdata_i[SVC_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tc_q <= '0;
      flags_q <= '0;
    end else if (ctrl_wr_o) begin
      tc_q <= bus_wdata_i[DATA_W-1 -: CNT_W];
      flags_q <= flags_from_nibble(bus_wdata_i[CTL_FLAG_W-1:0]);
    end
  end

  // A control write reloads from the value being written.
  assign reload_val_o = ctrl_wr_o ? bus_wdata_i[DATA_W-1 -: CNT_W] : tc_q;
  assign tc_o = tc_q;
  assign flags_o = flags_q;

  always_comb begin
    bus_rdata_o = '0;
    if (rd_en) begin
      if (word_idx == WORD_W'(IDX_CTRL)) begin
        bus_rdata_o = {tc_q, {RSV_W{1'b0}}, nibble_from_flags(flags_q)};
      end else if (word_idx == WORD_W'(IDX_COUNT)) begin
        bus_rdata_o = {{CNT_PAD_W{1'b0}}, cnt_i};
      end
    end
  end

endmodule

// File: rtl/kwdog_key.sv
module kwdog_key
  import kwdog_pkg::*;
#(
  parameter int unsigned SVC_W = 16,
  parameter logic [SVC_W-1:0] ARM_KEY = 16'h556C,
  parameter logic [SVC_W-1:0] FIRE_KEY = 16'hAA39
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             svc_wr_i,
  input  logic [SVC_W-1:0] svc_data_i,
  input  logic             block_i,
  output logic             fire_o,
  output logic             armed_o
);

  key_state_t state_q;
  key_state_t state_d;

  function automatic key_state_t key_next(input key_state_t s, input logic [SVC_W-1:0] d);
    key_state_t n;
    if (d == ARM_KEY) begin
      n = KEY_ARMED;
    end else begin
      n = KEY_IDLE;
    end
    if (s == KEY_IDLE && d != ARM_KEY) begin
      n = KEY_IDLE;
    end
    return n;
  endfunction

  always_comb begin
    state_d = state_q;
    if (svc_wr_i) begin
      state_d = key_next(state_q, svc_data_i);
    end
  end

  assign fire_o = svc_wr_i && !block_i && (state_q == KEY_ARMED) && (svc_data_i == FIRE_KEY);
  assign armed_o = (state_q == KEY_ARMED);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= KEY_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

endmodule

// File: rtl/kwdog_prescale.sv
module kwdog_prescale #(
  parameter int unsigned DIV_LOG2 = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic pre_en_i,
  output logic tick_o
);

  localparam logic [DIV_LOG2-1:0] PRE_LAST = {DIV_LOG2{1'b1}};

  logic [DIV_LOG2-1:0] pre_q;

  function automatic logic [DIV_LOG2-1:0] pre_inc(input logic [DIV_LOG2-1:0] v);
    return v + DIV_LOG2'(1);
  endfunction

  assign tick_o = run_i && (!pre_en_i || (pre_q == PRE_LAST));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else if (clr_i || !pre_en_i) begin
      pre_q <= '0;
    end else if (run_i) begin
      pre_q <= pre_inc(pre_q);
    end
  end

endmodule

// File: rtl/kwdog_counter.sv
module kwdog_counter #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic [CNT_W-1:0] tc_i,
  input  logic             tick_i,
  input  logic             rst_sel_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expired_o,
  output logic             expire_o,
  output logic             rst_req_o,
  output logic             nmi_req_o
);

  logic [CNT_W-1:0] cnt_q;
  logic             expired_q;
  logic             rst_q;
  logic             nmi_q;

  function automatic logic [CNT_W-1:0] cnt_dec(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  assign expire_o = tick_i && !load_i && !expired_q && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      expired_q <= 1'b0;
      rst_q <= 1'b0;
      nmi_q <= 1'b0;
    end else begin
      rst_q <= expire_o && rst_sel_i;
      nmi_q <= expire_o && !rst_sel_i;
      if (expire_o && rst_sel_i) begin
        expired_q <= 1'b1;
      end
      if (!expired_q) begin
        if (load_i) begin
          cnt_q <= reload_val_i;
        end else if (expire_o) begin
          cnt_q <= rst_sel_i ? cnt_q : tc_i;
        end else if (tick_i) begin
          cnt_q <= cnt_dec(cnt_q);
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign expired_o = expired_q;
  assign rst_req_o = rst_q;
  assign nmi_req_o = nmi_q;

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top
  import kwdog_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SVC_W = 16,
  parameter int unsigned DIV_LOG2 = 11,
  parameter logic [SVC_W-1:0] ARM_KEY = 16'h556C,
  parameter logic [SVC_W-1:0] FIRE_KEY = 16'hAA39
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  input  logic              dbg_freeze_i,
  output logic              rst_req_o,
  output logic              nmi_req_o
);

  logic             ctrl_wr;
  logic             svc_wr;
  logic [SVC_W-1:0] svc_data;
  logic [CNT_W-1:0] tc_q;
  logic [CNT_W-1:0] reload_val;
  logic [CNT_W-1:0] cnt;
  ctrl_flags_t      flags;
  logic             wd_en;
  logic             frz_en;
  logic             rst_sel;
  logic             pre_en;
  logic             frozen;
  logic             run;
  logic             load;
  logic             tick;
  logic             fire;
  logic             armed;
  logic             expired;
  logic             expire;

  assign wd_en = flags.wd_en;
  assign frz_en = flags.frz_en;
  assign rst_sel = flags.rst_sel;
  assign pre_en = flags.pre_en;
  assign frozen = frz_en && dbg_freeze_i;
  assign run = wd_en && !frozen && !expired;
  assign load = ctrl_wr || fire || !wd_en;

  kwdog_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .CNT_W (CNT_W),
    .SVC_W (SVC_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .bus_rdata_o (bus_rdata_o),
    .cnt_i       (cnt),
    .ctrl_wr_o   (ctrl_wr),
    .svc_wr_o    (svc_wr),
    .svc_data_o  (svc_data),
    .tc_o        (tc_q),
    .reload_val_o(reload_val),
    .flags_o     (flags)
  );

  kwdog_key #(
    .SVC_W   (SVC_W),
    .ARM_KEY (ARM_KEY),
    .FIRE_KEY(FIRE_KEY)
  ) u_key (
    .clk       (clk),
    .rst_n     (rst_n),
    .svc_wr_i  (svc_wr),
    .svc_data_i(svc_data),
    .block_i   (expired),
    .fire_o    (fire),
    .armed_o   (armed)
  );

  kwdog_prescale #(
    .DIV_LOG2(DIV_LOG2)
  ) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (load),
    .run_i   (run),
    .pre_en_i(pre_en),
    .tick_o  (tick)
  );

  kwdog_counter #(
    .CNT_W(CNT_W)
  ) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_i      (load),
    .reload_val_i(reload_val),
    .tc_i        (tc_q),
    .tick_i      (tick),
    .rst_sel_i   (rst_sel),
    .cnt_o       (cnt),
    .expired_o   (expired),
    .expire_o    (expire),
    .rst_req_o   (rst_req_o),
    .nmi_req_o   (nmi_req_o)
  );

endmodule

// File: rtl/kwdog_checker.sv
module kwdog_checker #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dbg_freeze_i,
  input logic             rst_req_o,
  input logic             nmi_req_o,
  input logic             tick,
  input logic             fire,
  input logic             armed,
  input logic             ctrl_wr,
  input logic             expired,
  input logic             expire,
  input logic             wd_en,
  input logic             frz_en,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] tc_q
);

  // R1: a completed key sequence reloads the counter
  p_fire_reload_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt == $past(tc_q)));

  // R2: a reload can only come from an armed sequence
  p_fire_needs_arm_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> armed);

  // R5: a plain tick with a nonzero count decrements by one
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (cnt != '0) && !ctrl_wr && !fire && !expired && wd_en)
      |=> (cnt == $past(cnt) - CNT_W'(1)));

  // R7: requests are exclusive and follow an expiry event
  p_out_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req_o, nmi_req_o}));

  p_expire_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (rst_req_o || nmi_req_o));

  p_nmi_reload_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_req_o |-> (cnt == tc_q));

  // R8: reset request is a single pulse and the counter then freezes
  p_rst_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  p_expired_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expired |=> $stable(cnt));

  // R9: disabled watchdog holds the reload value and stays quiet
  p_disabled_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wd_en && !ctrl_wr && !expired) |=> (cnt == $past(tc_q)));

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> (!rst_req_o && !nmi_req_o));

  // R10: freeze holds the count
  p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_en && dbg_freeze_i && !ctrl_wr && !fire) |=> $stable(cnt));

endmodule

bind kwdog_top kwdog_checker #(.CNT_W(CNT_W)) u_kwdog_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dbg_freeze_i(dbg_freeze_i),
  .rst_req_o   (rst_req_o),
  .nmi_req_o   (nmi_req_o),
  .tick        (tick),
  .fire        (fire),
  .armed       (armed),
  .ctrl_wr     (ctrl_wr),
  .expired     (expired),
  .expire      (expire),
  .wd_en       (wd_en),
  .frz_en      (frz_en),
  .cnt         (cnt),
  .tc_q        (tc_q)
);

// File: tb/kwdog_top_test.sv
module kwdog_top_test;

  localparam logic [3:0] A_ZERO = 4'h0;
  localparam logic [3:0] A_CTRL = 4'h4;
  localparam logic [3:0] A_MIS = 4'h5;
  localparam logic [3:0] A_CNT = 4'h8;
  localparam logic [3:0] A_SVC = 4'hC;
  localparam int PRE_DIV = 2048;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        dbg_freeze = 1'b0;
  logic        rst_req;
  logic        nmi_req;

  always #5 clk = ~clk;

  kwdog_top uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel_i   (bus_sel),
    .bus_wr_i    (bus_wr),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .dbg_freeze_i(dbg_freeze),
    .rst_req_o   (rst_req),
    .nmi_req_o   (nmi_req)
  );

  int n_chk = 0;
  int n_fail = 0;
  int nmi_seen = 0;
  int rst_seen = 0;

  typedef struct {
    logic [31:0] val;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard mid-cycle during every read, counts pulses.
  always @(negedge clk) begin
    exp_t e;
    if (rst_n) begin
      if (nmi_req) nmi_seen++;
      if (rst_req) rst_seen++;
      if (bus_sel && !bus_wr) begin
        if (sb_q.size() == 0) begin
          check("scoreboard empty", bus_rdata, 32'h0);
        end else begin
          e = sb_q.pop_front();
          check(e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  function automatic logic [31:0] cw(input int tc, input bit frz, input bit en,
                                     input bit rsel, input bit pre);
    return {tc[15:0], 12'h000, frz, en, rsel, pre};
  endfunction

  function automatic int period(input int tc, input bit pre);
    return (tc + 1) * (pre ? PRE_DIV : 1);
  endfunction

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic idle(input int n);
    repeat (n) step();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_sel = 1'b1;
    bus_wr = 1'b1;
    bus_addr = a;
    bus_wdata = d;
    step();
    bus_sel = 1'b0;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_t e;
    e.val = exp;
    e.tag = tag;
    sb_q.push_back(e);
    bus_sel = 1'b1;
    bus_wr = 1'b0;
    bus_addr = a;
    step();
    bus_sel = 1'b0;
  endtask

  task automatic measure(output int k, output bit is_rst);
    k = 0;
    while (k < 20000) begin
      @(negedge clk);
      if (nmi_req || rst_req) break;
      k++;
    end
    is_rst = rst_req;
    step();
  endtask

  initial begin
    int  k;
    bit  isr;
    int  n0;
    int  r0;
    idle(3);
    rst_n = 1'b1;
    step();

    // R11 reset state
    rd(A_CTRL, 32'h0, "R11 ctrl after reset");
    rd(A_CNT, 32'h0, "R11 count after reset");
    check("R11 request outputs low", {30'h0, rst_req, nmi_req}, 32'h0);

    // R3 field layout and reserved bits
    wr(A_CTRL, 32'h000A_FFFA);
    rd(A_CTRL, 32'h000A_000A, "R3 ctrl readback masks reserved");
    wr(A_CTRL, cw(10, 0, 0, 0, 0));
    rd(A_CTRL, 32'h000A_0000, "R3 ctrl readback");
    idle(5);
    rd(A_CNT, 32'd10, "R9 disabled count holds reload");

    // R4 count read-only, other addresses read zero
    wr(A_CNT, 32'h0000_1234);
    rd(A_CNT, 32'd10, "R4 count write ignored");
    rd(A_ZERO, 32'h0, "R4 offset 0 reads zero");
    rd(A_MIS, 32'h0, "R4 misaligned reads zero");
    rd(A_SVC, 32'h0, "R4 service reads zero");

    // R5 per-clock decrement and R7 NMI period
    wr(A_CTRL, cw(20, 0, 1, 0, 0));
    rd(A_CNT, 32'd20, "R5 count at load");
    rd(A_CNT, 32'd19, "R5 count after one clock");
    wr(A_CTRL, cw(20, 0, 1, 0, 0));
    measure(k, isr);
    check("R5 expiry delay", k, period(20, 0));
    check("R7 nmi chosen", {31'h0, isr}, 32'h0);
    n0 = nmi_seen;
    measure(k, isr);
    check("R7 nmi repeats after reload", k, period(20, 0) - 1);
    check("R7 nmi pulse count", nmi_seen - n0, 1);
    wr(A_CTRL, cw(20, 0, 0, 0, 0));

    // R1 regular servicing keeps it alive
    wr(A_CTRL, cw(20, 0, 1, 0, 0));
    n0 = nmi_seen;
    for (int i = 0; i < 5; i++) begin
      idle(15);
      wr(A_SVC, 32'h0000_556C);
      wr(A_SVC, 32'h0000_AA39);
    end
    rd(A_CNT, 32'd20, "R1 count after key pair");
    check("R1 no expiry while serviced", nmi_seen - n0, 0);

    // R2 ordering rules
    wr(A_CTRL, cw(20, 0, 1, 0, 0));
    idle(5);
    wr(A_SVC, 32'h0000_556C);
    wr(A_SVC, 32'h0000_1111);
    wr(A_SVC, 32'h0000_AA39);
    rd(A_CNT, 32'd12, "R2 other value disarms");
    wr(A_CTRL, cw(20, 0, 1, 0, 0));
    idle(5);
    wr(A_SVC, 32'h0000_556C);
    wr(A_SVC, 32'h0000_556C);
    wr(A_SVC, 32'h0000_AA39);
    rd(A_CNT, 32'd20, "R2 repeated arm stays armed");
    wr(A_CTRL, cw(20, 0, 1, 0, 0));
    idle(5);
    wr(A_SVC, 32'h0000_AA39);
    rd(A_CNT, 32'd14, "R2 unarmed second key ignored");
    wr(A_CTRL, cw(20, 0, 0, 0, 0));

    // R10 freeze
    dbg_freeze = 1'b1;
    wr(A_CTRL, cw(20, 1, 1, 0, 0));
    idle(10);
    rd(A_CNT, 32'd20, "R10 frozen count holds");
    wr(A_CTRL, cw(20, 0, 1, 0, 0));
    idle(3);
    rd(A_CNT, 32'd17, "R10 freeze input ignored when disabled");
    dbg_freeze = 1'b0;

    // R9 disable
    wr(A_CTRL, cw(5, 0, 1, 0, 0));
    idle(2);
    wr(A_CTRL, cw(5, 0, 0, 0, 0));
    rd(A_CNT, 32'd5, "R9 count returns to reload");
    n0 = nmi_seen;
    r0 = rst_seen;
    idle(30);
    rd(A_CNT, 32'd5, "R9 count held while disabled");
    check("R9 no pulses while disabled", (nmi_seen - n0) + (rst_seen - r0), 0);

    // R8 reset mode
    r0 = rst_seen;
    wr(A_CTRL, cw(5, 0, 1, 1, 0));
    measure(k, isr);
    check("R8 reset expiry delay", k, period(5, 0));
    check("R8 reset chosen", {31'h0, isr}, 32'h1);
    idle(20);
    rd(A_CNT, 32'd0, "R8 count stays expired");
    wr(A_SVC, 32'h0000_556C);
    wr(A_SVC, 32'h0000_AA39);
    rd(A_CNT, 32'd0, "R8 service ignored after reset expiry");
    wr(A_CTRL, cw(5, 0, 1, 0, 0));
    rd(A_CNT, 32'd0, "R8 ctrl write does not restart");
    idle(20);
    check("R8 single reset pulse", rst_seen - r0, 1);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    step();
    rd(A_CTRL, 32'h0, "R8 cleared by block reset");

    // R6 prescaler
    wr(A_CTRL, cw(2, 0, 1, 0, 1));
    idle(PRE_DIV - 1);
    rd(A_CNT, 32'd2, "R6 count before first prescaled tick");
    rd(A_CNT, 32'd1, "R6 count after first prescaled tick");
    wr(A_CTRL, cw(2, 0, 1, 0, 1));
    measure(k, isr);
    check("R6 prescaled expiry delay", k, period(2, 1));
    wr(A_CTRL, cw(2, 0, 0, 0, 0));

    idle(2);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule